// File: doc/BRIEF.md
# Chunked Command Mailbox Responder

This block sits on the device side of a 32-bit, word-addressed register window. A host posts a command by first writing how many result words it can take into the control/status word and then writing a nonzero opcode, with a queue index in the upper half, into the opcode word. The block passes the command to an internal handler over a valid/ready command stream. It takes the handler's result words from a valid/ready result stream and places them in a 16-word data window. It then offers them to the host one chunk at a time through a chunk-ready flag that the host clears to acknowledge each chunk.

The in-process flag tells the host whether more chunks follow. A 10-bit error field reports a handler failure and ends the transfer. The block signals that the command is fully finished by returning the opcode word to zero. Commands that carry no payload are acknowledged with an empty chunk. A legacy mode leaves the control word alone and acknowledges only by clearing the opcode word.

Back-pressure: `cmd_valid` stays high with stable fields until `cmd_ready`. The block lowers `res_ready` whenever it cannot take a result word: while a chunk waits for the host, once the requested count is met, or outside a command. The handler must hold `res_valid` and its fields until accepted, and it must mark the final word of a command, including an error word, with `res_last`.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the opcode word (address 0), the control word (address 1) and the reserved word (address 2) read zero, and `cmd_valid` and `res_ready` are low.
- R2: The control word holds the chunk size in bits 15:0, in-process in bit 16, chunk-ready in bit 17, the error code in bits 27:18, and zero in bits 31:28. An idle write to it loads bits 15:0 as the requested word count and clears bits 16, 17 and the error. The reserved word always reads zero and ignores writes.
- R3: A nonzero write to the opcode word while idle holds that value (opcode in bits 15:0, queue index in bits 31:16) and issues exactly one command carrying the opcode, the queue index and the requested count. Outside legacy mode it also sets in-process.
- R4: For opcode 2, result words fill the data window at addresses 3 to 18 from chunk offset 0. A chunk is offered, with its size and chunk-ready set, when the window is full, the handler's last word arrives, or the requested count is reached. In-process stays set while more chunks follow.
- R5: The sizes of all chunks together never exceed the requested count. Result words beyond it are discarded, and a zero request yields one empty final chunk.
- R6: A control write with bit 17 clear acknowledges an offered chunk, and only then may the next chunk be gathered. A control write with bit 17 set leaves the chunk offered, and no result word is accepted while chunk-ready is set.
- R7: The last chunk shows in-process clear. After the host acknowledges it and all handler words are consumed, the opcode word returns to zero.
- R8: A result word with a nonzero error ends the transfer with an offered chunk of size 0, in-process clear and that code in bits 27:18. Words gathered for the unfinished chunk are dropped.
- R9: Opcodes 1, 3 and 4 carry no payload. Their single handler word is acknowledged as a chunk of size 0 with in-process clear and the handler's error code.
- R10: In legacy mode the control word is not modified, and the opcode word returns to zero when the handler's last word is accepted.
- R11: A zero write to the opcode word clears the opcode word, chunk-ready, in-process and the error at once. Any outstanding handler words are then drained, and afterwards a new command runs normally.
- R12: A nonzero opcode write is ignored while a command is active, that is while the opcode word is nonzero or in-process is set without an error. No command is issued and the opcode word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Selects single-register acknowledge for commands started while high |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 5 | Host word address (read and write) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmd_valid | output | 1 | Command offered to the handler |
| cmd_ready | input | 1 | Handler accepts the command |
| cmd_opcode | output | 16 | Command opcode |
| cmd_qidx | output | 16 | Queue index of the command |
| cmd_words | output | 16 | Words the host asked for |
| res_valid | input | 1 | Handler result word valid |
| res_ready | output | 1 | Block accepts a result word |
| res_data | input | 32 | Result word |
| res_last | input | 1 | Final result word of the command |
| res_err | input | 10 | Error code, nonzero ends the command |

## Verification
A sequencer left in the wrong state shows up within one chunk. The host sees a size or in-process value that differs from the arithmetic split of the requested count into 16-word pieces, or a window word out of sequence. It may also see an opcode word that never clears, which the bench's bounded polling turns into a failure within a few thousand cycles. A broken acknowledge or abort path leaves chunk-ready set, drops it early, or hands out a second command. The sweep over request lengths 0 to 37 against short, exact and overlong handler streams reaches every chunk boundary.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;

  localparam int unsigned WORD_W = 32;

  // control word field positions
  localparam int unsigned SIZE_W     = 16;
  localparam int unsigned INPROC_BIT = 16;
  localparam int unsigned RDY_BIT    = 17;
  localparam int unsigned ERR_LSB    = 18;
  localparam int unsigned ERR_W      = 10;

  // word addresses of the register regions
  localparam int unsigned ADR_OPC  = 0;
  localparam int unsigned ADR_CTL  = 1;
  localparam int unsigned ADR_RSV  = 2;
  localparam int unsigned ADR_WIN  = 3;

  // the one opcode that returns data
  localparam logic [15:0] OPC_QSTATE = 16'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_FILL,
    ST_SHOW,
    ST_DRAIN,
    ST_LEGACY
  } mbx_state_e;

endpackage

// File: rtl/cmd_mailbox_window.sv
module cmd_mailbox_window #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);

  logic [31:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/cmd_mailbox_decode.sv
module cmd_mailbox_decode
  import cmd_mailbox_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       opc_word,
  input  logic [31:0]       ctl_word,
  input  logic [31:0]       win_word,
  output logic              op_wr,
  output logic              ctl_wr,
  output logic [IDX_W-1:0]  win_idx,
  output logic [31:0]       reg_rdata
);

  logic [ADDR_W-1:0] win_off;
  logic              in_win;

  assign win_off = reg_addr - ADDR_W'(ADR_WIN);
  assign in_win  = (reg_addr >= ADDR_W'(ADR_WIN)) && (win_off < ADDR_W'(DEPTH));
  assign win_idx = win_off[IDX_W-1:0];

  assign op_wr  = reg_wr_en && (reg_addr == ADDR_W'(ADR_OPC));
  assign ctl_wr = reg_wr_en && (reg_addr == ADDR_W'(ADR_CTL));

  always_comb begin
    if (reg_addr == ADDR_W'(ADR_OPC)) begin
      reg_rdata = opc_word;
    end else if (reg_addr == ADDR_W'(ADR_CTL)) begin
      reg_rdata = ctl_word;
    end else if (in_win) begin
      reg_rdata = win_word;
    end else begin
      reg_rdata = '0;
    end
  end

endmodule

// File: rtl/cmd_mailbox_seq.sv
module cmd_mailbox_seq
  import cmd_mailbox_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic             op_wr,
  input  logic             ctl_wr,
  input  logic [31:0]      wdata,
  output logic [31:0]      op_q,
  output logic [15:0]      ctl_size,
  output logic             ctl_inproc,
  output logic             ctl_rdy,
  output logic [ERR_W-1:0] ctl_err,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [15:0]      cmd_opcode,
  output logic [15:0]      cmd_qidx,
  output logic [15:0]      cmd_words,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic             res_last,
  input  logic [ERR_W-1:0] res_err,
  output logic             win_we,
  output logic [IDX_W-1:0] win_idx
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  mbx_state_e       st_q;
  logic [15:0]      rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             seen_last_q;
  logic             final_q;
  logic             nodata_q;
  logic             abort_q;
  logic             start;
  logic             accept;
  logic             close_dat;
  logic             fin_dat;

  assign start = op_wr && (wdata != '0) && (st_q == ST_IDLE) && (op_q == '0)
              && !(ctl_inproc && (ctl_err == '0));

  always_comb begin
    case (st_q)
      ST_FILL:   res_ready = !abort_q && (nodata_q || (rem_q != '0));
      ST_DRAIN:  res_ready = !seen_last_q;
      ST_LEGACY: res_ready = 1'b1;
      default:   res_ready = 1'b0;
    endcase
  end

  assign accept    = res_valid && res_ready;
  assign cnt_nxt   = cnt_q + 1'b1;
  assign fin_dat   = res_last || (rem_q == 16'd1);
  assign close_dat = fin_dat || (cnt_nxt == CNT_W'(DEPTH));
  assign cmd_valid = (st_q == ST_ISSUE);
  assign win_we    = (st_q == ST_FILL) && accept && !nodata_q && (res_err == '0);
  assign win_idx   = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      op_q        <= '0;
      ctl_size    <= '0;
      ctl_inproc  <= 1'b0;
      ctl_rdy     <= 1'b0;
      ctl_err     <= '0;
      cmd_opcode  <= '0;
      cmd_qidx    <= '0;
      cmd_words   <= '0;
      rem_q       <= '0;
      cnt_q       <= '0;
      seen_last_q <= 1'b0;
      final_q     <= 1'b0;
      nodata_q    <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ctl_wr) begin
            ctl_size   <= wdata[SIZE_W-1:0];
            ctl_inproc <= 1'b0;
            ctl_rdy    <= 1'b0;
            ctl_err    <= '0;
          end
          if (start) begin
            op_q        <= wdata;
            cmd_opcode  <= wdata[15:0];
            cmd_qidx    <= wdata[31:16];
            cmd_words   <= ctl_size;
            rem_q       <= ctl_size;
            nodata_q    <= (wdata[15:0] != OPC_QSTATE);
            cnt_q       <= '0;
            seen_last_q <= 1'b0;
            final_q     <= 1'b0;
            abort_q     <= 1'b0;
            st_q        <= ST_ISSUE;
            if (!legacy_mode) begin
              ctl_inproc <= 1'b1;
              ctl_rdy    <= 1'b0;
              ctl_err    <= '0;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            if (abort_q)          st_q <= ST_DRAIN;
            else if (!ctl_inproc) st_q <= ST_LEGACY;
            else                  st_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (abort_q) begin
            st_q <= seen_last_q ? ST_IDLE : ST_DRAIN;
          end else if (!nodata_q && (rem_q == '0)) begin
            ctl_size   <= 16'(cnt_q);
            ctl_rdy    <= 1'b1;
            ctl_inproc <= 1'b0;
            final_q    <= 1'b1;
            st_q       <= ST_SHOW;
          end else if (accept) begin
            if (res_last) seen_last_q <= 1'b1;
            if (nodata_q || (res_err != '0)) begin
              ctl_size   <= '0;
              ctl_err    <= res_err;
              ctl_rdy    <= 1'b1;
              ctl_inproc <= 1'b0;
              final_q    <= 1'b1;
              st_q       <= ST_SHOW;
            end else begin
              cnt_q <= cnt_nxt;
              rem_q <= rem_q - 16'd1;
              if (close_dat) begin
                ctl_size   <= 16'(cnt_nxt);
                ctl_rdy    <= 1'b1;
                ctl_inproc <= !fin_dat;
                final_q    <= fin_dat;
                st_q       <= ST_SHOW;
              end
            end
          end
        end
        ST_SHOW: begin
          if (abort_q) begin
            st_q <= seen_last_q ? ST_IDLE : ST_DRAIN;
          end else if (ctl_wr && !wdata[RDY_BIT]) begin
            ctl_rdy <= 1'b0;
            if (final_q) begin
              if (seen_last_q) begin
                op_q <= '0;
                st_q <= ST_IDLE;
              end else begin
                st_q <= ST_DRAIN;
              end
            end else begin
              cnt_q <= '0;
              st_q  <= ST_FILL;
            end
          end
        end
        ST_DRAIN: begin
          if (seen_last_q || (accept && res_last)) begin
            op_q <= '0;
            st_q <= ST_IDLE;
          end
        end
        ST_LEGACY: begin
          if (accept && res_last) begin
            op_q <= '0;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      // host clear of the opcode word wins over the sequencer
      if (op_wr && (wdata == '0)) begin
        op_q       <= '0;
        ctl_rdy    <= 1'b0;
        ctl_inproc <= 1'b0;
        ctl_err    <= '0;
        if (st_q != ST_IDLE) abort_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [15:0]       cmd_opcode,
  output logic [15:0]       cmd_qidx,
  output logic [15:0]       cmd_words,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [31:0]       res_data,
  input  logic              res_last,
  input  logic [9:0]        res_err
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             op_wr;
  logic             ctl_wr;
  logic [31:0]      op_q;
  logic [15:0]      ctl_size;
  logic             ctl_inproc;
  logic             ctl_rdy;
  logic [ERR_W-1:0] ctl_err;
  logic [31:0]      ctl_word;
  logic             win_we;
  logic [IDX_W-1:0] win_wr_idx;
  logic [IDX_W-1:0] win_rd_idx;
  logic [31:0]      win_word;

  assign ctl_word = {4'b0000, ctl_err, ctl_rdy, ctl_inproc, ctl_size};

  cmd_mailbox_decode #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .opc_word  (op_q),
    .ctl_word  (ctl_word),
    .win_word  (win_word),
    .op_wr     (op_wr),
    .ctl_wr    (ctl_wr),
    .win_idx   (win_rd_idx),
    .reg_rdata (reg_rdata)
  );

  cmd_mailbox_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .op_wr       (op_wr),
    .ctl_wr      (ctl_wr),
    .wdata       (reg_wdata),
    .op_q        (op_q),
    .ctl_size    (ctl_size),
    .ctl_inproc  (ctl_inproc),
    .ctl_rdy     (ctl_rdy),
    .ctl_err     (ctl_err),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_opcode  (cmd_opcode),
    .cmd_qidx    (cmd_qidx),
    .cmd_words   (cmd_words),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_last    (res_last),
    .res_err     (res_err),
    .win_we      (win_we),
    .win_idx     (win_wr_idx)
  );

  cmd_mailbox_window #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (win_we),
    .wr_idx  (win_wr_idx),
    .wr_data (res_data),
    .rd_idx  (win_rd_idx),
    .rd_data (win_word)
  );

endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_wr,
  input logic        ctl_wr,
  input logic [31:0] wdata,
  input logic [31:0] op_q,
  input logic [15:0] ctl_size,
  input logic        ctl_inproc,
  input logic        ctl_rdy,
  input logic [9:0]  ctl_err,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] cmd_opcode,
  input logic        res_valid,
  input logic        res_ready
);

  // R4: an offered chunk never exceeds the window
  p_chunk_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdy |-> (ctl_size <= 16'(DEPTH)));

  // R6: chunk stays offered until the host writes
  p_hold_chunk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdy && !ctl_wr && !op_wr) |=> ctl_rdy);

  // R6: no result word taken while a chunk waits
  p_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdy |-> !res_ready);

  // R8: an error never coexists with in-process
  p_err_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_err != '0) |-> !ctl_inproc);

  // R3: command offer is held stable
  p_cmd_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode)));

  // R12: nonzero opcode write while active leaves the opcode word alone
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && (wdata != '0) && (op_q != '0) && !(res_valid && res_ready))
      |=> (op_q == $past(op_q)));

  // R11: zero opcode write clears the mailbox in the next cycle
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && (wdata == '0)) |=> ((op_q == '0) && !ctl_rdy && !ctl_inproc && (ctl_err == '0)));

endmodule

bind cmd_mailbox cmd_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_wr      (op_wr),
  .ctl_wr     (ctl_wr),
  .wdata      (reg_wdata),
  .op_q       (op_q),
  .ctl_size   (ctl_size),
  .ctl_inproc (ctl_inproc),
  .ctl_rdy    (ctl_rdy),
  .ctl_err    (ctl_err),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_opcode (cmd_opcode),
  .res_valid  (res_valid),
  .res_ready  (res_ready)
);

// File: tb/cmd_mailbox_tb_top.sv
module cmd_mailbox_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_mode = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [15:0] cmd_opcode, cmd_qidx, cmd_words;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [31:0] res_data = '0;
  logic        res_last = 1'b0;
  logic [9:0]  res_err = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // stub handler configuration and capture
  int          st_beats = 1;
  int          st_err_at = -1;
  logic [9:0]  st_err_val = '0;
  int          st_tag = 0;
  int          cmd_cnt = 0;
  bit          stub_busy = 0;
  logic [15:0] cap_op, cap_q, cap_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_qidx(cmd_qidx), .cmd_words(cmd_words),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_last(res_last), .res_err(res_err)
  );

  function automatic logic [31:0] pat(int tag, int k);
    return 32'h5A00_0000 + 32'(tag * 256) + 32'(k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_rdy(input string req, output logic [31:0] v);
    for (int i = 0; i < 3000; i++) begin
      rd(5'd1, v);
      if (v[17]) return;
    end
    chk(req, v, 32'h0002_0000);
  endtask

  task automatic wait_op_clear(input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(5'd0, v);
      if (v == '0) break;
    end
    chk(req, v, 32'h0);
  endtask

  task automatic wait_stub_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!stub_busy && !cmd_valid) break;
    end
  endtask

  // stub command handler
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        cmd_ready = 1'b1;
        cap_op = cmd_opcode; cap_q = cmd_qidx; cap_w = cmd_words;
        stub_busy = 1;
        @(negedge clk);
        cmd_ready = 1'b0;
        cmd_cnt++;
        for (int k = 0; k < st_beats; k++) begin
          res_valid = 1'b1;
          res_data  = pat(st_tag, k);
          res_last  = (k == st_beats - 1) || (k == st_err_at);
          res_err   = (k == st_err_at) ? st_err_val : 10'd0;
          while (!res_ready) @(negedge clk);
          @(negedge clk);
          if (res_last) break;
        end
        res_valid = 1'b0; res_last = 1'b0; res_err = '0;
        stub_busy = 0;
      end
    end
  end

  // data-returning command with an arithmetic model of the chunk split
  task automatic run_read(input int n, input int m, input int q, input int err_at,
                          input logic [9:0] err_val);
    logic [31:0] v;
    int rem, k, base, cnt, esz;
    bit efin;
    logic [9:0] eerr;
    st_beats = m; st_err_at = err_at; st_err_val = err_val; st_tag = n;
    wr(5'd1, 32'(n));
    wr(5'd0, {16'(q), 16'd2});
    rem = n; k = 0; base = 0; efin = 0;
    while (!efin) begin
      cnt = 0; eerr = '0;
      forever begin
        if (rem == 0) begin efin = 1; break; end
        if (k == err_at) begin eerr = err_val; cnt = 0; efin = 1; k++; break; end
        cnt++; rem--; k++;
        if (k == m || cnt == WIN || rem == 0) begin efin = (k == m) || (rem == 0); break; end
      end
      esz = cnt;
      wait_rdy("R4 chunk offer", v);
      chk("R4 chunk size", {16'h0, v[15:0]}, 32'(esz));
      chk("R7 in-process", {31'h0, v[16]}, {31'h0, !efin});
      chk("R8 error field", {22'h0, v[27:18]}, {22'h0, eerr});
      chk("R2 top bits", {28'h0, v[31:28]}, 32'h0);
      for (int i = 0; i < esz; i++) begin
        logic [31:0] w;
        rd(5'(3 + i), w);
        chk("R4 window word", w, pat(n, base + i));
      end
      base += esz;
      wr(5'd1, v & ~32'h0002_0000);
    end
    chk("R5 total words", 32'(base), 32'((err_at >= 0 && err_at < n) ? 0 : 0) + 32'(base));
    if (err_at < 0) chk("R5 total capped", 32'(base), 32'((m < n) ? m : n));
    wait_op_clear("R7 opcode cleared");
    chk("R3 cmd opcode", {16'h0, cap_op}, 32'd2);
    chk("R3 cmd qidx", {16'h0, cap_q}, 32'(q));
    chk("R3 cmd words", {16'h0, cap_w}, 32'(n));
    wait_stub_idle();
  endtask

  task automatic run_nodata(input logic [15:0] opc, input logic [9:0] ev);
    logic [31:0] v;
    st_beats = 1; st_err_at = (ev != 0) ? 0 : -1; st_err_val = ev; st_tag = 99;
    wr(5'd1, 32'h0);
    wr(5'd0, {16'h0, opc});
    wait_rdy("R9 ack offer", v);
    chk("R9 empty ack", v, {4'h0, ev, 1'b1, 1'b0, 16'h0});
    wr(5'd1, v & ~32'h0002_0000);
    wait_op_clear("R9 opcode cleared");
    chk("R9 opcode passed", {16'h0, cap_op}, {16'h0, opc});
    wait_stub_idle();
  endtask

  initial begin
    logic [31:0] v;
    int cc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'd0, v); chk("R1 opcode reset", v, 32'h0);
    rd(5'd1, v); chk("R1 control reset", v, 32'h0);
    rd(5'd2, v); chk("R1 reserved reset", v, 32'h0);
    chk("R1 idle streams", {30'h0, cmd_valid, res_ready}, 32'h0);

    // R2 layout and reserved word
    wr(5'd1, 32'hFFFF_FFFF);
    rd(5'd1, v); chk("R2 idle control load", v, 32'h0000_FFFF);
    wr(5'd2, 32'hDEAD_BEEF);
    rd(5'd2, v); chk("R2 reserved ignores writes", v, 32'h0);
    rd(5'd0, v); chk("R2 opcode untouched", v, 32'h0);

    // R4 R5 R7 sweep of request lengths against handler lengths
    for (int n = 0; n <= 37; n++) begin
      run_read(n, (n == 0) ? 1 : n, n + 1, -1, '0);
      run_read(n, n + 2, 16'hA000 + n, -1, '0);
      if (n / 2 + 1 < n) run_read(n, n / 2 + 1, 7, -1, '0);
    end

    // R8 error termination
    run_read(20, 20, 3, 0, 10'h155);
    run_read(20, 20, 4, 5, 10'h001);
    run_read(20, 20, 5, 17, 10'h3FF);
    run_read(40, 40, 6, 33, 10'h0A5);

    // R9 payload-free commands
    run_nodata(16'd1, 10'd0);
    run_nodata(16'd3, 10'd0);
    run_nodata(16'd4, 10'd0);
    run_nodata(16'd3, 10'd7);
    run_nodata(16'd1, 10'h200);

    // R6 acknowledge rules and R12 busy opcode write
    st_beats = 20; st_err_at = -1; st_tag = 20;
    wr(5'd1, 32'd20);
    wr(5'd0, {16'd9, 16'd2});
    wait_rdy("R6 first chunk", v);
    chk("R6 first chunk word", v, 32'h0003_0010);
    cc = cmd_cnt;
    wr(5'd1, v);
    repeat (8) @(negedge clk);
    rd(5'd1, v); chk("R6 write with flag set keeps chunk", v, 32'h0003_0010);
    rd(5'd3, v); chk("R6 window held", v, pat(20, 0));
    wr(5'd0, 32'h0000_0003);
    repeat (4) @(negedge clk);
    rd(5'd0, v); chk("R12 opcode kept", v, {16'd9, 16'd2});
    chk("R12 no new command", 32'(cmd_cnt), 32'(cc));
    wr(5'd1, 32'h0001_0010);
    wait_rdy("R6 second chunk", v);
    chk("R6 second chunk word", v, 32'h0002_0004);
    rd(5'd3, v); chk("R6 second chunk data", v, pat(20, 16));
    wr(5'd1, 32'h0000_0004);
    wait_op_clear("R7 opcode cleared after final ack");
    wait_stub_idle();

    // R11 abort mid-transfer
    st_beats = 30; st_err_at = -1; st_tag = 30;
    wr(5'd1, 32'd30);
    wr(5'd0, {16'd1, 16'd2});
    wait_rdy("R11 chunk before abort", v);
    wr(5'd0, 32'h0);
    rd(5'd0, v); chk("R11 opcode cleared", v, 32'h0);
    rd(5'd1, v); chk("R11 flags cleared", {4'h0, v[27:16], 16'h0}, 32'h0);
    wait_stub_idle();
    chk("R11 handler drained", {31'h0, stub_busy}, 32'h0);
    run_nodata(16'd4, 10'd0);

    // R10 legacy acknowledge
    legacy_mode = 1'b1;
    st_beats = 3; st_err_at = -1; st_tag = 5;
    cc = cmd_cnt;
    wr(5'd1, 32'd5);
    wr(5'd0, 32'h0000_0001);
    wait_op_clear("R10 legacy opcode cleared");
    rd(5'd1, v); chk("R10 control untouched", v, 32'h0000_0005);
    chk("R10 one command", 32'(cmd_cnt), 32'(cc + 1));
    legacy_mode = 1'b0;
    wait_stub_idle();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule